// File: doc/BRIEF.md
# Hashed page table group searcher

This block walks one page-table entry group held in memory and looks for a translation whose first word matches a virtual tag prepared by the caller. The caller supplies the byte address of the group, the primary/secondary hash flag, the tag, the protection key, the kind of access (load, store or fetch) and a no-execute flag. The engine then reads the entries one word at a time through a request/valid memory port. It checks each entry and turns the two protection bits of a matching entry into access rights.

Scanning stops at the first matching entry that grants the access. A match that refuses the access is remembered and scanning goes on. Two matches that disagree on page number or attributes abort the search. When an entry is selected, its referenced flag is set, and on a granted store its changed flag is set too. The second word is written back only when those flags actually changed.

The controller has six states. ST_IDLE waits for start. ST_READ0 fetches word 0 of the current slot. ST_READ1 fetches word 1. ST_CHECK evaluates the slot. ST_WRITEBACK stores the updated word 1. ST_DONE raises the completion pulse. The transitions are:
- start in ST_IDLE moves to ST_READ0.
- A read response moves ST_READ0 to ST_READ1, and ST_READ1 to ST_CHECK.
- ST_CHECK moves to ST_READ0 for the next slot, to ST_WRITEBACK when a selected word changed, or to ST_DONE.
- A write acknowledge moves ST_WRITEBACK to ST_DONE.
- ST_DONE always returns to ST_IDLE.

Top module: `hpt_group_search`

## Requirements
- R1: Entry i of the group has word 0 at byte address base+8*i and word 1 at base+8*i+4. Slots are read in ascending order, one read at a time, word 0 before word 1. A request holds mem_req, mem_we and mem_addr steady until mem_rvalid is seen with it, and every read address lies inside the group (SLOTS*8 bytes from base).
- R2: An entry is a candidate only when bit 31 of word 0 is 1, bit 6 of word 0 equals sec_hash, and word 0 ANDed with 0x7FFFFFBF equals vtag. vtag is given with bits 31 and 6 clear.
- R3: Rights come from key and the two least significant bits of word 1 (pp).
  - With key 0, pp 0, 1 and 2 allow load and store, and pp 3 allows load only.
  - With key 1, pp 0 allows nothing, pp 1 and pp 3 allow load only, and pp 2 allows load and store.
  - acc encodes 0 = load, 1 = store, 2 = fetch, and 3 is always refused.
  - A fetch is allowed when a load is allowed and no_exec is 0.
- R4: The first candidate that allows the access ends the scan with result 0 (granted). slot gives its index and pte_word1 gives its updated word 1. No further slot is read.
- R5: A candidate that refuses the access is recorded and the scan continues. If no later candidate grants, the result is 1 (refused) and the slot is the last refusing candidate, after all SLOTS slots have been read.
- R6: Once a candidate has been recorded, a later candidate whose word 1 differs from the recorded word 1 under the mask PAGE_MASK | 0x7B ends the search at once with result 3 (inconsistent). pte_word1 and slot are 0 and nothing is written.
- R7: With no candidate among all SLOTS slots, the result is 2 (miss), pte_word1 and slot are 0, and nothing is written.
- R8: For result 0 or 1, the reported word 1 is the selected word 1 with bit 8 (referenced) set. Bit 7 (changed) is also set only for a granted store.
- R9: A write of the reported word 1 to base+8*slot+4 happens exactly once when it differs from the word read, and never otherwise.
- R10: done is a one-cycle pulse at the end of each search. result, slot and pte_word1 keep their values until the next search finishes. start is ignored while a search is in progress.
- R11: After reset the block is idle with done, mem_req and mem_we at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken in ST_IDLE only) |
| grp_base | input | ADDR_W | Byte address of the entry group |
| sec_hash | input | 1 | Primary (0) or secondary (1) hash flag |
| vtag | input | 32 | Expected word 0 with bits 31 and 6 clear |
| key | input | 1 | Protection key |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| no_exec | input | 1 | Forbid fetch access |
| mem_req | output | 1 | Memory request, held until mem_rvalid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid / write acknowledge |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 granted, 1 refused, 2 miss, 3 inconsistent |
| pte_word1 | output | 32 | Updated word 1 of the selected slot |
| slot | output | SLOT_W | Index of the selected slot |

## Verification
The bench builds the block with its default parameters: eight slots, a 32-bit address and a 4 KiB page mask. A 128-byte memory model then holds two whole groups. With eight slots, a sweep over every key, protection code, access kind, no-execute value and prior referenced/changed state also moves the matching entry through every slot position, so the first and last slots are reached. The small group lets directed cases place decoys, two refusing matches, and inconsistent pairs that differ only in a page-number bit or only in an attribute bit, at exact positions. The read count and addresses can then be predicted for every run.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ0,
        ST_READ1,
        ST_CHECK,
        ST_WRITEBACK,
        ST_DONE
    } hpt_state_e;

    typedef enum logic [1:0] {
        RES_GRANT = 2'd0,
        RES_DENY  = 2'd1,
        RES_MISS  = 2'd2,
        RES_CLASH = 2'd3
    } hpt_res_e;

    localparam logic [1:0]  ACC_LOAD  = 2'd0;
    localparam logic [1:0]  ACC_STORE = 2'd1;
    localparam logic [1:0]  ACC_FETCH = 2'd2;

    localparam int          VALID_BIT = 31;
    localparam int          HASH_BIT  = 6;
    localparam logic [31:0] TAG_MASK  = 32'h7FFF_FFBF;
    localparam logic [31:0] ATTR_MASK = 32'h0000_007B;
    localparam logic [31:0] REF_FLAG  = 32'h0000_0100;
    localparam logic [31:0] CHG_FLAG  = 32'h0000_0080;

endpackage

// File: rtl/hpt_rights.sv
module hpt_rights
    import hpt_pkg::*;
(
    input  logic       key,
    input  logic [1:0] pp,
    input  logic       no_exec,
    input  logic [1:0] acc,
    output logic       allow
);
    logic may_load;
    logic may_store;

    always_comb begin
        unique case ({key, pp})
            3'b000, 3'b001, 3'b010: begin may_load = 1'b1; may_store = 1'b1; end
            3'b011:                 begin may_load = 1'b1; may_store = 1'b0; end
            3'b100:                 begin may_load = 1'b0; may_store = 1'b0; end
            3'b101, 3'b111:         begin may_load = 1'b1; may_store = 1'b0; end
            3'b110:                 begin may_load = 1'b1; may_store = 1'b1; end
            default:                begin may_load = 1'b0; may_store = 1'b0; end
        endcase
        unique case (acc)
            ACC_LOAD:  allow = may_load;
            ACC_STORE: allow = may_store;
            ACC_FETCH: allow = may_load && !no_exec;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/hpt_flags.sv
module hpt_flags
    import hpt_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              set_changed,
    output logic [WORD_W-1:0] word_out,
    output logic              dirty
);
    always_comb begin
        word_out = word_in | WORD_W'(REF_FLAG);
        if (set_changed) word_out = word_out | WORD_W'(CHG_FLAG);
        dirty = (word_out != word_in);
    end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          SLOTS     = 8,
    parameter logic [31:0] PAGE_MASK = 32'hFFFF_F000,
    localparam int         SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] grp_base,
    input  logic              sec_hash,
    input  logic [31:0]       vtag,
    input  logic              key,
    input  logic [1:0]        acc,
    input  logic              no_exec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [1:0]        result,
    output logic [31:0]       pte_word1,
    output logic [SLOT_W-1:0] slot
);
    localparam int          WORD_W      = 32;
    localparam int          ENTRY_SHIFT = 3;
    localparam int          GROUP_BYTES = SLOTS << ENTRY_SHIFT;
    localparam logic [31:0] CMP_MASK    = PAGE_MASK | ATTR_MASK;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    hpt_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic              hsel_q, key_q, nx_q;
    logic [1:0]        acc_q;
    logic [31:0]       tag_q;
    logic [SLOT_W-1:0] idx_q;
    logic [WORD_W-1:0] w0_q, w1_q, sel_w1_q, outw_q;
    logic [SLOT_W-1:0] sel_slot_q, outslot_q;
    logic              have_q;
    hpt_res_e          res_q, res_d;

    logic              cand, clash, allow, last, dirty;
    logic [WORD_W-1:0] pick_w1, upd_w1;
    logic [SLOT_W-1:0] pick_slot;

    hpt_rights u_rights (
        .key     (key_q),
        .pp      (w1_q[1:0]),
        .no_exec (nx_q),
        .acc     (acc_q),
        .allow   (allow)
    );

    hpt_flags #(.WORD_W(WORD_W)) u_flags (
        .word_in     (pick_w1),
        .set_changed (cand && allow && (acc_q == ACC_STORE)),
        .word_out    (upd_w1),
        .dirty       (dirty)
    );

    // slot evaluation
    always_comb begin
        cand = w0_q[VALID_BIT] && (w0_q[HASH_BIT] == hsel_q)
               && ((w0_q & TAG_MASK) == tag_q);
        clash     = cand && have_q && ((w1_q & CMP_MASK) != (sel_w1_q & CMP_MASK));
        last      = (idx_q == LAST_SLOT);
        pick_w1   = cand ? w1_q  : sel_w1_q;
        pick_slot = cand ? idx_q : sel_slot_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_READ0;
            ST_READ0:     if (mem_rvalid) state_d = ST_READ1;
            ST_READ1:     if (mem_rvalid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (clash) begin
                    res_d   = RES_CLASH;
                    state_d = ST_DONE;
                end else if (cand && allow) begin
                    res_d   = RES_GRANT;
                    state_d = dirty ? ST_WRITEBACK : ST_DONE;
                end else if (last) begin
                    if (have_q || cand) begin
                        res_d   = RES_DENY;
                        state_d = dirty ? ST_WRITEBACK : ST_DONE;
                    end else begin
                        res_d   = RES_MISS;
                        state_d = ST_DONE;
                    end
                end else begin
                    state_d = ST_READ0;
                end
            end
            ST_WRITEBACK: if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            hsel_q     <= 1'b0;
            key_q      <= 1'b0;
            nx_q       <= 1'b0;
            acc_q      <= ACC_LOAD;
            tag_q      <= '0;
            idx_q      <= '0;
            w0_q       <= '0;
            w1_q       <= '0;
            sel_w1_q   <= '0;
            sel_slot_q <= '0;
            have_q     <= 1'b0;
            res_q      <= RES_GRANT;
            outw_q     <= '0;
            outslot_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q <= grp_base;
                    hsel_q <= sec_hash;
                    tag_q  <= vtag;
                    key_q  <= key;
                    acc_q  <= acc;
                    nx_q   <= no_exec;
                    idx_q  <= '0;
                    have_q <= 1'b0;
                end
                ST_READ0: if (mem_rvalid) w0_q <= mem_rdata;
                ST_READ1: if (mem_rvalid) w1_q <= mem_rdata;
                ST_CHECK: begin
                    if (cand && !clash) begin
                        sel_w1_q   <= w1_q;
                        sel_slot_q <= idx_q;
                        have_q     <= 1'b1;
                    end
                    if (state_d == ST_READ0) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        res_q <= res_d;
                        if (res_d == RES_GRANT || res_d == RES_DENY) begin
                            outw_q    <= upd_w1;
                            outslot_q <= pick_slot;
                        end else begin
                            outw_q    <= '0;
                            outslot_q <= '0;
                        end
                    end
                end
                ST_WRITEBACK, ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_READ0: begin
                mem_req  = 1'b1;
                mem_addr = base_q + (ADDR_W'(idx_q) << ENTRY_SHIFT);
            end
            ST_READ1: begin
                mem_req  = 1'b1;
                mem_addr = base_q + (ADDR_W'(idx_q) << ENTRY_SHIFT) + ADDR_W'(4);
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q + (ADDR_W'(outslot_q) << ENTRY_SHIFT) + ADDR_W'(4);
                mem_wdata = outw_q;
            end
            ST_IDLE, ST_CHECK, ST_DONE: ;
            default: ;
        endcase
        done      = (state_q == ST_DONE);
        result    = res_q;
        pte_word1 = outw_q;
        slot      = outslot_q;
    end

    // ---------------- assertions ----------------
    assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_read_in_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ((mem_addr - base_q) < ADDR_W'(GROUP_BYTES)));

    assert_ref_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[8] && mem_addr[2:0] == 3'b100));

    assert_clash_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_CLASH) |-> !$past(mem_we));

    assert_miss_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_MISS) |-> (!$past(mem_we) && pte_word1 == '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && start) |=> (mem_req || done || state_q == ST_CHECK));

endmodule

// File: tb/hpt_group_search_tb.sv
module hpt_group_search_tb_top;
    localparam logic [31:0] TAG = 32'h1ABC_DE2A & 32'h7FFF_FFBF;
    localparam logic [31:0] RPN = 32'h0ABC_D028;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] grp_base = '0;
    logic        sec_hash = 1'b0;
    logic [31:0] vtag = '0;
    logic        key = 1'b0;
    logic [1:0]  acc = 2'd0;
    logic        no_exec = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  result;
    logic [31:0] pte_word1;
    logic [2:0]  slot;

    logic [31:0] mem [0:31];
    int          wr_cnt = 0, rd_cnt = 0, rd_err = 0;
    logic [31:0] wr_addr = '0, wr_data = '0;
    logic [31:0] rd_base = '0;
    int          rd_mark = 0;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    hpt_group_search dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_base(grp_base),
        .sec_hash(sec_hash), .vtag(vtag), .key(key), .acc(acc), .no_exec(no_exec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .result(result),
        .pte_word1(pte_word1), .slot(slot)
    );

    // memory model: one-cycle response, reads from mem, writes recorded
    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_rvalid;
        if (mem_req && !mem_rvalid && !mem_we) begin
            mem_rdata <= mem[mem_addr[6:2]];
            if (mem_addr != rd_base + 32'(4 * (rd_cnt - rd_mark))) rd_err <= rd_err + 1;
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_req && !mem_rvalid && mem_we) begin
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
            wr_data <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) mem[i] = '0;
    endtask

    function automatic logic exp_allow(input logic k, input logic [1:0] pp,
                                       input logic [1:0] a, input logic nx);
        logic ld, st;
        ld = !(k && pp == 2'd0);
        st = k ? (pp == 2'd2) : (pp != 2'd3);
        if (a == 2'd0) return ld;
        if (a == 2'd1) return st;
        if (a == 2'd2) return ld && !nx;
        return 1'b0;
    endfunction

    task automatic wait_done(output logic ok);
        int g = 0;
        while (done !== 1'b1 && g < 500) begin
            @(negedge clk);
            g++;
        end
        ok = (done === 1'b1);
        if (!ok) chk("watchdog", 32'd0, 32'd1);
    endtask

    task automatic run_case(input logic [31:0] base, input logic hs, input logic k,
                            input logic [1:0] a, input logic nx,
                            input logic [1:0] e_res, input logic [2:0] e_slot,
                            input logic [31:0] e_w1, input logic e_wr, input int e_reads,
                            input string req);
        int w0, r0, er0;
        logic ok;
        @(negedge clk);
        grp_base = base; sec_hash = hs; vtag = TAG; key = k; acc = a; no_exec = nx;
        rd_base = base; rd_mark = rd_cnt;
        w0 = wr_cnt; r0 = rd_cnt; er0 = rd_err;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (!ok) return;
        chk({req, " result"}, 32'(result), 32'(e_res));
        chk({req, " slot"}, 32'(slot), 32'(e_slot));
        chk({req, " word1 R8"}, pte_word1, e_w1);
        chk("R9 write count", 32'(wr_cnt - w0), e_wr ? 32'd1 : 32'd0);
        if (e_wr) begin
            chk("R9 write addr", wr_addr, base + 32'(slot) * 8 + 4);
            chk("R9 write data", wr_data, e_w1);
        end
        chk("R1 read count", 32'(rd_cnt - r0), 32'(e_reads));
        chk("R1 read order", 32'(rd_err - er0), 32'd0);
        @(negedge clk);
        chk("R10 done pulse", 32'(done), 32'd0);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 mem_req", 32'(mem_req), 32'd0);
        chk("R11 mem_we", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle", 32'(mem_req), 32'd0);

        // R3 R4 R5 R8 R9 sweep: one candidate, moving across every slot
        begin
            int n = 0;
            for (int kk = 0; kk < 2; kk++)
            for (int pp = 0; pp < 4; pp++)
            for (int ac = 0; ac < 3; ac++)
            for (int nx = 0; nx < 2; nx++)
            for (int rc = 0; rc < 4; rc++) begin
                int s;
                logic hs, al;
                logic [31:0] orig, upd;
                s  = n % 8;
                hs = 1'(n / 8);
                clear_mem();
                mem[2*s]   = 32'h8000_0000 | TAG | (32'(hs) << 6);
                mem[2*s+1] = RPN | 32'(pp) | (32'(rc) << 7);
                orig = mem[2*s+1];
                al = exp_allow(1'(kk), 2'(pp), 2'(ac), 1'(nx));
                upd = orig | 32'h100 | ((al && ac == 1) ? 32'h80 : 32'h0);
                run_case(32'd0, hs, 1'(kk), 2'(ac), 1'(nx),
                         al ? 2'd0 : 2'd1, 3'(s), upd, upd != orig,
                         al ? 2 * (s + 1) : 16, al ? "R3 R4 grant" : "R3 R5 refuse");
                n++;
            end
        end

        // R2 R7 decoys only: miss, all slots read, nothing written
        for (int h = 0; h < 2; h++) begin
            clear_mem();
            mem[16] = TAG | (32'(h) << 6);                                    // invalid
            mem[17] = RPN;
            mem[18] = 32'h8000_0000 | TAG | (32'(1 - h) << 6);                // wrong hash flag
            mem[19] = RPN;
            mem[20] = 32'h8000_0000 | (TAG ^ 32'h1000) | (32'(h) << 6);       // tag bit differs
            mem[21] = RPN;
            mem[22] = 32'h8000_0000 | (TAG ^ 32'h1) | (32'(h) << 6);
            mem[23] = RPN;
            run_case(32'd64, 1'(h), 1'b0, 2'd0, 1'b0, 2'd2, 3'd0, 32'd0, 1'b0, 16, "R2 R7 miss");
        end

        // R5 two consistent refusing matches: last one reported
        clear_mem();
        mem[2] = 32'h8000_0000 | TAG; mem[3] = RPN | 32'h4;
        mem[8] = 32'h8000_0000 | TAG; mem[9] = RPN | 32'h80;
        run_case(32'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd1, 3'd4, RPN | 32'h180, 1'b1, 16, "R5 last refusal");

        // R6 page-number clash
        clear_mem();
        mem[2] = 32'h8000_0000 | TAG; mem[3] = RPN;
        mem[6] = 32'h8000_0000 | TAG; mem[7] = RPN ^ 32'h1000;
        run_case(32'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd3, 3'd0, 32'd0, 1'b0, 8, "R6 rpn clash");

        // R6 attribute clash (bit 6)
        clear_mem();
        mem[18] = 32'h8000_0040 | TAG; mem[19] = RPN;
        mem[22] = 32'h8000_0040 | TAG; mem[23] = RPN | 32'h40;
        run_case(32'd64, 1'b1, 1'b1, 2'd0, 1'b0, 2'd3, 3'd0, 32'd0, 1'b0, 8, "R6 attr clash");

        // R4 first grant stops before a conflicting later entry
        clear_mem();
        mem[0] = 32'h8000_0000 | TAG; mem[1] = RPN | 32'h2;
        mem[2] = 32'h8000_0000 | TAG; mem[3] = 32'h0123_4000;
        run_case(32'd0, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 3'd0, RPN | 32'h182, 1'b1, 2, "R4 first grant");

        // R10 start while busy is ignored; outputs held after done
        clear_mem();
        mem[6]  = 32'h8000_0000 | TAG; mem[7]  = RPN | 32'h102;
        mem[16] = 32'h8000_0000 | TAG; mem[17] = RPN | 32'h3;
        begin
            logic ok;
            @(negedge clk);
            grp_base = 32'd0; sec_hash = 1'b0; vtag = TAG; key = 1'b0; acc = 2'd0; no_exec = 1'b0;
            rd_base = 32'd0; rd_mark = rd_cnt;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (3) @(negedge clk);
            grp_base = 32'd64; key = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0;
            wait_done(ok);
            chk("R10 busy start result", 32'(result), 32'd0);
            chk("R10 busy start slot", 32'(slot), 32'd3);
            chk("R10 busy start word1", pte_word1, RPN | 32'h102);
            repeat (4) @(negedge clk);
            chk("R10 hold result", 32'(result), 32'd0);
            chk("R10 hold slot", 32'(slot), 32'd3);
            chk("R10 idle after", 32'(mem_req), 32'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule